// File: doc/BRIEF.md
# I2C Programmable Bit Timing Generator

This block produces the SCL waveform and the SDA timing strobes for an I2C controller from one packed timing word. A programmable prescaler divides the kernel clock into ticks. Separate counts set the length of the SCL low phase and the SCL high phase. Inside the low phase, a hold delay sets when the transfer engine may change SDA. A setup delay then sets how long SDA must stay stable before SCL is released.

The SCL and SDA inputs pass through a two-flop synchroniser. The high-phase count starts only once the synchronised SCL reads high. A target that holds SCL low therefore stretches the bit. The transfer engine raises `run` to clock bits back to back. It receives a strobe for each of three points: when SDA may change, when SCL has been seen high (with the sampled SDA value), and when the bit ends.

The timing word can be loaded only while the block is disabled. Clearing `enable` releases SCL at once. The low and high counts are independent, so one register layout covers two cases: standard mode with equal phases, and the faster modes with the low phase twice the high phase, up to 1 MHz.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset and while idle, `sclDriveLow`, `sdaChangeStb`, `sampleStb` and `bitDoneStb` are all 0.
- R2: One tick lasts P+1 kernel clocks, where P is `cfgData[3:0]`. Each low phase and each high phase begins on a fresh tick boundary.
- R3: `sclDriveLow` stays high for max(L+1, D+S+1)·(P+1) cycles. Here L = `cfgData[11:4]`, D = `cfgData[23:20]` and S = `cfgData[27:24]`.
- R4: `sdaChangeStb` pulses once per low phase, exactly D·(P+1) cycles after the first cycle of `sclDriveLow`. When D = 0 it pulses in that first cycle.
- R5: SCL is not released until at least S+1 ticks after the `sdaChangeStb` tick. When D+S+1 exceeds L+1, the setup delay alone sets the low length.
- R6: After `sampleStb`, the high phase lasts (H+1)·(P+1) cycles, where H = `cfgData[19:12]`. It ends with `bitDoneStb` in its last cycle.
- R7: With no stretching, `sampleStb` comes in the third cycle after SCL is released. Each extra clock edge on which the bus holds `sclIn` low delays it by one cycle.
- R8: `rxBit` takes the synchronised `sdaIn` value at `sampleStb`, and holds it until the next `sampleStb`.
- R9: `cfgWrite` loads `cfgData` only while `enable` is 0. A write while `enable` is 1 leaves the timing unchanged.
- R10: When `enable` is 0, `sclDriveLow` is 0 from the next cycle on, and the block stays idle.
- R11: When `run` is high at `bitDoneStb`, the next low phase begins in the following cycle. When `run` is low, the block goes idle and produces no further strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; 0 forces idle and allows configuration |
| cfgWrite | input | 1 | Load strobe for the timing word |
| cfgData | input | 28 | Packed timing word: P[3:0], L[11:4], H[19:12], D[23:20], S[27:24] |
| run | input | 1 | Transfer engine requests bit clocking |
| sclIn | input | 1 | Observed SCL bus level |
| sdaIn | input | 1 | Observed SDA bus level |
| sclDriveLow | output | 1 | 1 pulls SCL low; 0 releases it |
| sdaChangeStb | output | 1 | SDA may change in this cycle |
| sampleStb | output | 1 | SCL seen high; SDA is sampled |
| bitDoneStb | output | 1 | Last cycle of the bit |
| rxBit | output | 1 | SDA value captured at the last sample |

## Verification
The hardest case to reach is a stretched bit that meets the synchroniser latency, because the extra delay is visible only as a longer gap between the release of SCL and `sampleStb`. The bench models the bus as a wired-AND of the block's drive and a target hold. A counter keeps `sclIn` low for a chosen number of edges after each release, so the expected gap can be computed to the cycle. The setup-dominated low phase, the zero hold delay and a write attempted while enabled are each reached with their own timing word.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

  typedef enum logic [1:0] {
    BT_IDLE = 2'd0,
    BT_LOW  = 2'd1,
    BT_WAIT = 2'd2,
    BT_HIGH = 2'd3
  } btState_e;

  // control -> datapath
  typedef struct packed {
    logic restart;   // clear prescaler and tick count
    logic sample;    // capture synchronised SDA
  } btCtl_t;

  // datapath -> control
  typedef struct packed {
    logic lowDone;   // last tick of the low phase
    logic highDone;  // last tick of the high phase
    logic holdHit;   // hold delay reached
  } btStat_t;

endpackage

// File: rtl/i2c_bt_sync.sv
module i2c_bt_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '1;
    else       chain[0] <= asyncIn;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '1;
        else       chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/i2c_bt_datapath.sv
module i2c_bt_datapath
  import i2c_bt_pkg::*;
#(
  parameter int PRESC_W = 4,
  parameter int LOW_W   = 8,
  parameter int HIGH_W  = 8,
  parameter int DEL_W   = 4,
  localparam int CFG_W  = PRESC_W + LOW_W + HIGH_W + 2*DEL_W,
  localparam int CNT_W  = ((LOW_W > HIGH_W) ? LOW_W : HIGH_W) + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cfgWrite,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             sdaSync,
  input  btCtl_t           ctl,
  output btStat_t          stat,
  output logic             rxBit
);
  localparam int LOW_LSB  = PRESC_W;
  localparam int HIGH_LSB = LOW_LSB + LOW_W;
  localparam int HOLD_LSB = HIGH_LSB + HIGH_W;
  localparam int SET_LSB  = HOLD_LSB + DEL_W;

  logic [CFG_W-1:0]   cfgQ;
  logic [PRESC_W-1:0] prescVal;
  logic [LOW_W-1:0]   lowVal;
  logic [HIGH_W-1:0]  highVal;
  logic [DEL_W-1:0]   holdVal;
  logic [DEL_W-1:0]   setupVal;
  logic [PRESC_W-1:0] presCnt;
  logic [CNT_W-1:0]   tickCnt;
  logic [CNT_W-1:0]   lowSpan;
  logic [CNT_W-1:0]   delSpan;
  logic [CNT_W-1:0]   lowNeed;
  logic [CNT_W-1:0]   highNeed;
  logic               tick;

  // timing word is frozen while enabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    cfgQ <= '0;
    else if (cfgWrite && !enable) cfgQ <= cfgData;
  end

  assign prescVal = cfgQ[PRESC_W-1:0];
  assign lowVal   = cfgQ[LOW_LSB  +: LOW_W];
  assign highVal  = cfgQ[HIGH_LSB +: HIGH_W];
  assign holdVal  = cfgQ[HOLD_LSB +: DEL_W];
  assign setupVal = cfgQ[SET_LSB  +: DEL_W];

  assign lowSpan  = CNT_W'(lowVal) + CNT_W'(1);
  assign delSpan  = CNT_W'(holdVal) + CNT_W'(setupVal) + CNT_W'(1);
  assign lowNeed  = (lowSpan > delSpan) ? lowSpan : delSpan;
  assign highNeed = CNT_W'(highVal) + CNT_W'(1);

  // prescaled time base
  assign tick = (presCnt == prescVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            presCnt <= '0;
    else if (ctl.restart) presCnt <= '0;
    else if (tick)        presCnt <= '0;
    else                  presCnt <= presCnt + PRESC_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tickCnt <= '0;
    else if (ctl.restart) tickCnt <= '0;
    else if (tick && (tickCnt != '1)) tickCnt <= tickCnt + CNT_W'(1);
  end

  assign stat.lowDone  = tick && ((tickCnt + CNT_W'(1)) >= lowNeed);
  assign stat.highDone = tick && ((tickCnt + CNT_W'(1)) >= highNeed);
  assign stat.holdHit  = (tickCnt == CNT_W'(holdVal));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rxBit <= 1'b1;
    else if (ctl.sample) rxBit <= sdaSync;
  end

  p_presc_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    presCnt <= prescVal);

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(enable) |-> $stable(cfgQ));

endmodule

// File: rtl/i2c_bt_ctrl.sv
module i2c_bt_ctrl
  import i2c_bt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    run,
  input  logic    sclSync,
  input  btStat_t stat,
  output btCtl_t  ctl,
  output logic    sclDriveLow,
  output logic    sdaChangeStb,
  output logic    sampleStb,
  output logic    bitDoneStb
);
  btState_e state, nextState;
  logic     sdaDone;

  always_comb begin
    nextState = state;
    unique case (state)
      BT_IDLE: if (run)           nextState = BT_LOW;
      BT_LOW:  if (stat.lowDone)  nextState = BT_WAIT;
      BT_WAIT: if (sclSync)       nextState = BT_HIGH;
      BT_HIGH: if (stat.highDone) nextState = run ? BT_LOW : BT_IDLE;
      default:                    nextState = BT_IDLE;
    endcase
    if (!enable) nextState = BT_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= BT_IDLE;
    else       state <= nextState;
  end

  assign sclDriveLow  = (state == BT_LOW);
  assign sdaChangeStb = (state == BT_LOW) && !sdaDone && stat.holdHit && enable;
  assign sampleStb    = (state == BT_WAIT) && sclSync && enable;
  assign bitDoneStb   = (state == BT_HIGH) && stat.highDone && enable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sdaDone <= 1'b0;
    else if (state != BT_LOW)  sdaDone <= 1'b0;
    else if (sdaChangeStb)     sdaDone <= 1'b1;
  end

  assign ctl.restart = (nextState != state) || (state == BT_IDLE) || (state == BT_WAIT);
  assign ctl.sample  = sampleStb;

  p_disable_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !sclDriveLow);

  p_sda_before_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == BT_LOW && nextState == BT_WAIT) |-> (sdaDone || sdaChangeStb));

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sdaChangeStb, sampleStb, bitDoneStb}));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == BT_IDLE) |-> !(sclDriveLow || sampleStb || bitDoneStb));

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2c_bt_pkg::*;
#(
  parameter int PRESC_W   = 4,
  parameter int LOW_W     = 8,
  parameter int HIGH_W    = 8,
  parameter int DEL_W     = 4,
  parameter int SYNC_DEPTH = 2,
  localparam int CFG_W    = PRESC_W + LOW_W + HIGH_W + 2*DEL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cfgWrite,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             run,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sclDriveLow,
  output logic             sdaChangeStb,
  output logic             sampleStb,
  output logic             bitDoneStb,
  output logic             rxBit
);
  btCtl_t     ctl;
  btStat_t    stat;
  logic [1:0] busSync;

  i2c_bt_sync #(.WIDTH(2), .STAGES(SYNC_DEPTH)) i_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({sclIn, sdaIn}),
    .syncOut (busSync)
  );

  i2c_bt_datapath #(
    .PRESC_W(PRESC_W), .LOW_W(LOW_W), .HIGH_W(HIGH_W), .DEL_W(DEL_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .cfgWrite (cfgWrite),
    .cfgData  (cfgData),
    .sdaSync  (busSync[0]),
    .ctl      (ctl),
    .stat     (stat),
    .rxBit    (rxBit)
  );

  i2c_bt_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .run          (run),
    .sclSync      (busSync[1]),
    .stat         (stat),
    .ctl          (ctl),
    .sclDriveLow  (sclDriveLow),
    .sdaChangeStb (sdaChangeStb),
    .sampleStb    (sampleStb),
    .bitDoneStb   (bitDoneStb)
  );
endmodule

// File: tb/test_i2c_bit_timer.sv
module test_i2c_bit_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [27:0] cfgData = '0;
  logic        run = 1'b0;
  logic        sdaIn = 1'b1;
  logic        sclIn;
  logic        sclDriveLow, sdaChangeStb, sampleStb, bitDoneStb, rxBit;

  int stretchCycles = 0;
  int stretchLeft = 0;
  logic prevDrv = 1'b0;

  int nChecks = 0;
  int nFail = 0;
  bit monOn = 1'b1;

  typedef struct {
    int lowLen; int holdOff; int waitLen; int highLen; bit rx;
  } bitExp_t;
  bitExp_t expQ[$];

  int bitsStarted = 0;
  int bitsDone = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign sclIn = !(sclDriveLow || (stretchLeft > 0));

  i2c_bit_timer i_i2c_bit_timer (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWrite(cfgWrite),
    .cfgData(cfgData), .run(run), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclDriveLow(sclDriveLow), .sdaChangeStb(sdaChangeStb),
    .sampleStb(sampleStb), .bitDoneStb(bitDoneStb), .rxBit(rxBit)
  );

  task automatic check(input string req, input int act, input int expv);
    nChecks++;
    if (act != expv) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // target clock-stretch model
  always @(negedge clk) begin
    if (prevDrv && !sclDriveLow && stretchCycles > 0) stretchLeft = stretchCycles;
    else if (stretchLeft > 0) stretchLeft = stretchLeft - 1;
    prevDrv = sclDriveLow;
  end

  // monitor
  bit inLow = 0, inWait = 0, inHigh = 0;
  int lowCnt, holdOff, waitCnt, highCnt, lowRec;
  always @(negedge clk) begin
    if (monOn && rstN) begin
      if (sclDriveLow) begin
        if (!inLow) begin
          inLow = 1; lowCnt = 0; holdOff = -1; bitsStarted++;
        end
        lowCnt++;
        if (sdaChangeStb) holdOff = lowCnt - 1;
      end else begin
        if (inLow) begin
          inLow = 0; lowRec = lowCnt; inWait = 1; waitCnt = 0;
        end
        if (inWait) begin
          waitCnt++;
          if (sampleStb) begin inWait = 0; inHigh = 1; highCnt = 0; end
        end else if (inHigh) begin
          highCnt++;
          if (bitDoneStb) begin
            bitExp_t e;
            inHigh = 0; bitsDone++;
            if (expQ.size() == 0) check("R11 unexpected bit", 1, 0);
            else begin
              e = expQ.pop_front();
              check("R3 low length", lowRec, e.lowLen);
              check("R4 hold offset", holdOff, e.holdOff);
              check("R7 release-to-sample", waitCnt, e.waitLen);
              check("R6 high length", highCnt, e.highLen);
              check("R8 sampled SDA", int'(rxBit), int'(e.rx));
            end
          end
        end
      end
    end
  end

  task automatic loadCfg(input int p, input int l, input int h, input int d, input int s);
    @(negedge clk);
    enable = 0;
    cfgData = {4'(s), 4'(d), 8'(h), 8'(l), 4'(p)};
    cfgWrite = 1;
    @(negedge clk);
    cfgWrite = 0;
  endtask

  // driver: pushes expectations, then clocks n bits
  task automatic runBits(input int p, input int l, input int h, input int d, input int s,
                         input int n, input int str, input bit sda);
    int need;
    int target;
    need = ((l + 1) > (d + s + 1)) ? (l + 1) : (d + s + 1);
    for (int i = 0; i < n; i++) begin
      bitExp_t e;
      e.lowLen = need * (p + 1);
      e.holdOff = d * (p + 1);
      e.waitLen = 3 + str;
      e.highLen = (h + 1) * (p + 1);
      e.rx = sda;
      expQ.push_back(e);
    end
    target = bitsDone + n;
    stretchCycles = str;
    sdaIn = sda;
    @(negedge clk);
    enable = 1;
    run = 1;
    wait (bitsStarted == target);
    @(negedge clk);
    run = 0;
    wait (bitsDone == target);
    repeat (4) @(negedge clk);
    stretchCycles = 0;
  endtask

  initial begin
    int idleDone;
    repeat (3) @(negedge clk);
    check("R1 reset sclDriveLow", sclDriveLow, 0);
    check("R1 reset strobes", {sdaChangeStb, sampleStb, bitDoneStb}, 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    check("R1 idle sclDriveLow", sclDriveLow, 0);

    // R2 R3 R6: standard-style equal phases, no prescale
    loadCfg(0, 3, 3, 1, 1);
    runBits(0, 3, 3, 1, 1, 3, 0, 1'b1);
    // R11: idle after run drops
    idleDone = bitsDone;
    repeat (30) @(negedge clk);
    check("R11 idle after run low", sclDriveLow, 0);
    check("R11 no further bits", bitsDone, idleDone);

    // R2: fast-style 2:1 with prescale 3 clocks/tick
    loadCfg(2, 5, 2, 2, 1);
    runBits(2, 5, 2, 2, 1, 2, 0, 1'b0);

    // R5: setup delay dominates low length
    loadCfg(1, 1, 1, 3, 4);
    runBits(1, 1, 1, 3, 4, 2, 0, 1'b1);

    // R4: zero hold delay, prescale 4
    loadCfg(3, 0, 0, 0, 0);
    runBits(3, 0, 0, 0, 0, 2, 0, 1'b0);

    // R7: clock stretching by the target
    loadCfg(0, 3, 3, 1, 1);
    runBits(0, 3, 3, 1, 1, 2, 5, 1'b1);

    // R9: write while enabled is ignored
    loadCfg(2, 5, 2, 2, 1);
    @(negedge clk);
    enable = 1;
    cfgData = {4'd4, 4'd3, 8'd1, 8'd1, 4'd1};
    cfgWrite = 1;
    @(negedge clk);
    cfgWrite = 0;
    runBits(2, 5, 2, 2, 1, 1, 0, 1'b0);

    // R10: disable mid-bit releases SCL next cycle
    monOn = 0;
    loadCfg(0, 20, 20, 1, 1);
    @(negedge clk);
    enable = 1; run = 1;
    wait (sclDriveLow);
    @(negedge clk);
    enable = 0;
    @(negedge clk);
    check("R10 released after disable", sclDriveLow, 0);
    run = 1;
    repeat (10) begin
      @(negedge clk);
      if (sclDriveLow || sampleStb || bitDoneStb) check("R10 stays idle", 1, 0);
    end
    check("R10 still released", sclDriveLow, 0);
    run = 0;

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule